// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a simple synchronous requester and an asynchronous DRAM that is four bits wide and has multiplexed address pins. A requester offers a word address, a read/write flag and write data with a valid/ready handshake. The block turns each accepted request into the row-strobe, column-strobe, write-enable and output-enable sequence the memory expects. Every interval is counted in clock cycles by parameterised down-counters.

After a row has been opened, the block leaves it open. Later requests to the same row are served by column-strobe cycles alone. A request to a different row, a due refresh, or the approach of the longest time the row strobe may stay low makes the block close the page, wait out the precharge time and start again. Refresh is of the column-before-row kind, so the memory supplies the row address from its own counter.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are 1, `dram_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 0.
- R2: The row is `req_addr[19:10]` and is on `dram_addr` when `dram_ras_n` falls. The column is `req_addr[9:0]` and is on `dram_addr` when `dram_cas_n` falls.
- R3: A request with `req_we`=1 is a write: at the fall of the column strobe `dram_we_n` is 0, `dram_dq_oe` is 1 and `dram_dq_out` carries `req_wdata`. A request with `req_we`=0 is a read: `dram_we_n` is 1 and `dram_oe_n` is 0. The data sampled at the end of the `T_CAS`-cycle column pulse appears on `rd_data` with a one-cycle `rd_valid` pulse, and reads return in request order.
- R4: A request to the open row causes no new row activation. Successive column-strobe falls within one row are at least `T_CAS`+`T_CP` cycles apart.
- R5: After the row strobe rises it stays high for at least `T_RP` cycles before it falls again.
- R6: The row strobe stays low for at least `T_RAS` cycles before it rises.
- R7: The row strobe never stays low for more than `T_RAS_MAX`+`T_CAS`+`T_CP`+2 cycles. An idle open page is closed once `T_RAS_MAX` cycles have passed, even when no request is waiting.
- R8: A refresh is started every `REF_INTERVAL` cycles. The column strobe falls while the row strobe is high, and the row strobe falls one cycle later. A due refresh closes an open page and takes priority over waiting requests.
- R9: The first column strobe of a row falls at least `T_RCD` cycles after the row strobe fell.
- R10: `req_ready` is high only in the cycle in which a column access to the open row is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered; held until accepted |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | 20 | Word address, row in the upper half |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 4 | Read data |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 4 | Data returned by the memory |

## Verification
The interesting overlap is a refresh deadline that expires while a stream of page hits keeps the row busy. The refresh request must then win over the very next hit, close the page after the current column cycle and reopen the row afterwards. The bench provokes this with a long unbroken run of mixed writes and reads to one row that spans several refresh intervals. It judges the result by counting column-before-row events and row activations in a memory model, and by checking every read against a scoreboard, so that no data is lost or reordered across the forced closure.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_OPEN,
        ST_COL_ACCESS,
        ST_PRECHARGE,
        ST_REFRESH
    } fpm_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
    } fpm_strobe_t;

    localparam fpm_strobe_t STROBE_REST = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
    localparam fpm_strobe_t STROBE_PAGE = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    function automatic int fpm_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int fpm_bits(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/fpm_downcnt.sv
module fpm_downcnt #(
    parameter int W       = 4,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/fpm_page_tracker.sv
module fpm_page_tracker #(
    parameter int RW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          open_en,
    input  logic [RW-1:0] open_row,
    input  logic          close_en,
    input  logic [RW-1:0] probe_row,
    output logic          hit
);
    logic          page_vld;
    logic [RW-1:0] page_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_vld <= 1'b0;
            page_row <= '0;
        end else if (open_en) begin
            page_vld <= 1'b1;
            page_row <= open_row;
        end else if (close_en) begin
            page_vld <= 1'b0;
        end
    end

    assign hit = page_vld && (page_row == probe_row);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W        = 10,
    parameter int COL_W        = 10,
    parameter int DQ_W         = 4,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_CP         = 2,
    parameter int T_RP         = 6,
    parameter int T_RAS        = 7,
    parameter int T_RAS_MAX    = 9000,
    parameter int REF_INTERVAL = 1500,
    localparam int ADDR_W      = ROW_W + COL_W,
    localparam int PIN_W       = fpm_max(ROW_W, COL_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    output logic [PIN_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DQ_W-1:0]   dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DQ_W-1:0]   dram_dq_in
);
    localparam int PH_MAX = fpm_max(fpm_max(T_RCD, T_CAS), fpm_max(T_CP, fpm_max(T_RP, T_RAS)));
    localparam int PH_W   = fpm_bits(PH_MAX);
    localparam int AGE_W  = fpm_bits(T_RAS_MAX);
    localparam int REF_W  = fpm_bits(REF_INTERVAL);

    fpm_state_e      st;
    fpm_strobe_t     strb;
    logic [PIN_W-1:0] addr_q;
    logic [DQ_W-1:0] dq_q;
    logic            dq_oe_q;
    logic            rd_pend;
    logic            rd_valid_q;
    logic [DQ_W-1:0] rd_data_q;
    logic            ref_due;
    logic            ref_phase;

    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    assign req_row = req_addr[ADDR_W-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];

    // Timer outputs
    logic ph_zero, rmin_zero, age_zero, ref_zero;
    logic ph_load;
    logic [PH_W-1:0] ph_val;
    logic hit;

    // Decisions taken this cycle
    logic close_need;
    logic do_open, do_ref, do_col, do_close, col_end, ref_ras, ref_end, pre_end;

    always_comb begin
        close_need = ref_due || age_zero || (req_valid && !hit);
        do_ref     = (st == ST_IDLE) && ref_due;
        do_open    = (st == ST_IDLE) && !ref_due && req_valid;
        do_col     = (st == ST_ROW_OPEN) && ph_zero && req_valid && hit && !close_need;
        do_close   = (st == ST_ROW_OPEN) && ph_zero && close_need && rmin_zero;
        col_end    = (st == ST_COL_ACCESS) && ph_zero;
        ref_ras    = (st == ST_REFRESH) && ph_zero && !ref_phase;
        ref_end    = (st == ST_REFRESH) && ph_zero && ref_phase;
        pre_end    = (st == ST_PRECHARGE) && ph_zero;
    end

    always_comb begin
        ph_load = do_open | do_ref | do_col | do_close | col_end | ref_ras | ref_end;
        ph_val  = '0;
        if (do_open)       ph_val = PH_W'(T_RCD - 1);
        else if (do_col)   ph_val = PH_W'(T_CAS - 1);
        else if (col_end)  ph_val = PH_W'(T_CP - 1);
        else if (ref_ras)  ph_val = PH_W'(T_RAS - 1);
        else if (do_close || ref_end) ph_val = PH_W'(T_RP - 1);
    end

    // Phase timer: length of the current strobe phase
    fpm_downcnt #(.W(PH_W), .RST_VAL(0)) u_ph_tmr (
        .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
    );

    // Minimum row-strobe low time
    fpm_downcnt #(.W(PH_W), .RST_VAL(0)) u_rmin_tmr (
        .clk(clk), .rst(rst), .load(do_open), .load_val(PH_W'(T_RAS - 1)), .zero(rmin_zero)
    );

    // Page age: forces closure before the low-time ceiling
    fpm_downcnt #(.W(AGE_W), .RST_VAL(0)) u_age_tmr (
        .clk(clk), .rst(rst), .load(do_open), .load_val(AGE_W'(T_RAS_MAX - 1)), .zero(age_zero)
    );

    // Refresh interval, free running
    fpm_downcnt #(.W(REF_W), .RST_VAL(REF_INTERVAL - 1)) u_ref_tmr (
        .clk(clk), .rst(rst), .load(ref_zero), .load_val(REF_W'(REF_INTERVAL - 1)), .zero(ref_zero)
    );

    fpm_page_tracker #(.RW(ROW_W)) u_page (
        .clk      (clk),
        .rst      (rst),
        .open_en  (do_open),
        .open_row (req_row),
        .close_en (do_close),
        .probe_row(req_row),
        .hit      (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            strb       <= STROBE_REST;
            addr_q     <= '0;
            dq_q       <= '0;
            dq_oe_q    <= 1'b0;
            rd_pend    <= 1'b0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
            ref_due    <= 1'b0;
            ref_phase  <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            if (ref_zero)    ref_due <= 1'b1;
            else if (do_ref) ref_due <= 1'b0;

            unique case (st)
                ST_IDLE: begin
                    if (do_ref) begin
                        strb.cas_n <= 1'b0;
                        ref_phase  <= 1'b0;
                        st         <= ST_REFRESH;
                    end else if (do_open) begin
                        strb.ras_n <= 1'b0;
                        addr_q     <= PIN_W'(req_row);
                        st         <= ST_ROW_OPEN;
                    end
                end
                ST_ROW_OPEN: begin
                    if (do_col) begin
                        strb.cas_n <= 1'b0;
                        strb.we_n  <= ~req_we;
                        strb.oe_n  <= req_we;
                        addr_q     <= PIN_W'(req_col);
                        dq_q       <= req_wdata;
                        dq_oe_q    <= req_we;
                        rd_pend    <= ~req_we;
                        st         <= ST_COL_ACCESS;
                    end else if (do_close) begin
                        strb.ras_n <= 1'b1;
                        st         <= ST_PRECHARGE;
                    end
                end
                ST_COL_ACCESS: begin
                    if (col_end) begin
                        strb    <= STROBE_PAGE;
                        dq_oe_q <= 1'b0;
                        if (rd_pend) begin
                            rd_valid_q <= 1'b1;
                            rd_data_q  <= dram_dq_in;
                        end
                        st <= ST_ROW_OPEN;
                    end
                end
                ST_PRECHARGE: begin
                    if (pre_end) st <= ST_IDLE;
                end
                ST_REFRESH: begin
                    if (ref_ras) begin
                        strb.ras_n <= 1'b0;
                        ref_phase  <= 1'b1;
                    end else if (ref_end) begin
                        strb <= STROBE_REST;
                        st   <= ST_PRECHARGE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready   = do_col;
    assign rd_valid    = rd_valid_q;
    assign rd_data     = rd_data_q;
    assign dram_addr   = addr_q;
    assign dram_ras_n  = strb.ras_n;
    assign dram_cas_n  = strb.cas_n;
    assign dram_we_n   = strb.we_n;
    assign dram_oe_n   = strb.oe_n;
    assign dram_dq_out = dq_q;
    assign dram_dq_oe  = dq_oe_q;
endmodule

// File: rtl/fpm_dram_ctrl_sva.sv
module fpm_dram_ctrl_sva
    import fpm_pkg::*;
#(
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 2,
    parameter int T_CP      = 2,
    parameter int T_RP      = 6,
    parameter int T_RAS     = 7,
    parameter int T_RAS_MAX = 9000
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic rd_valid,
    input logic dram_ras_n,
    input logic dram_cas_n,
    input logic dram_we_n,
    input logic dram_dq_oe
);
    localparam int LIMIT = T_RAS_MAX + T_CAS + T_CP + 2;
    localparam int LO_W  = fpm_bits(LIMIT + 1);
    localparam int HI_W  = fpm_bits(T_RP);

    logic [LO_W-1:0] lo_cnt;
    logic [HI_W-1:0] hi_cnt;

    // Consecutive cycles the row strobe has been low / high
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= '0;
            hi_cnt <= HI_W'(T_RP);
        end else if (dram_ras_n) begin
            lo_cnt <= '0;
            if (hi_cnt != HI_W'(T_RP)) hi_cnt <= hi_cnt + HI_W'(1);
        end else begin
            hi_cnt <= '0;
            if (lo_cnt != LO_W'(LIMIT + 1)) lo_cnt <= lo_cnt + LO_W'(1);
        end
    end

    a_r1_idle_no_drive: assert property (@(posedge clk) disable iff (rst)
        (dram_ras_n && dram_cas_n) |-> !dram_dq_oe);

    a_r3_write_in_row: assert property (@(posedge clk) disable iff (rst)
        (!dram_cas_n && !dram_we_n) |-> (!dram_ras_n && dram_dq_oe));

    a_r3_rd_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    a_r5_precharge_min: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_ras_n) |-> (hi_cnt >= HI_W'(T_RP)));

    a_r6_ras_low_min: assert property (@(posedge clk) disable iff (rst)
        $rose(dram_ras_n) |-> (lo_cnt >= LO_W'(T_RAS)));

    a_r7_ras_low_max: assert property (@(posedge clk) disable iff (rst)
        lo_cnt <= LO_W'(LIMIT));

    a_r8_cbr_order: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_cas_n) && dram_ras_n) |=> $fell(dram_ras_n));

    a_r9_rcd_min: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_cas_n) && !dram_ras_n) |-> (lo_cnt >= LO_W'(T_RCD)));

    a_r10_ready_in_page: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (req_valid && !dram_ras_n && dram_cas_n));
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_sva #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_RAS(T_RAS), .T_RAS_MAX(T_RAS_MAX)
) u_sva (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n),
    .dram_we_n (dram_we_n),
    .dram_dq_oe(dram_dq_oe)
);

// File: tb/fpm_dram_ctrl_bench.sv
module fpm_dram_ctrl_bench;
    localparam int T_RCD        = 2;
    localparam int T_CAS        = 2;
    localparam int T_CP         = 2;
    localparam int T_RP         = 6;
    localparam int T_RAS        = 7;
    localparam int T_RAS_MAX    = 200;
    localparam int REF_INTERVAL = 400;
    localparam int LIMIT        = T_RAS_MAX + T_CAS + T_CP + 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [3:0]  req_wdata = '0;
    logic        rd_valid;
    logic [3:0]  rd_data;
    logic [9:0]  dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
    logic [3:0]  dram_dq_out;
    logic        dram_dq_oe;
    logic [3:0]  rdq = '0;

    always #5 clk = ~clk;

    fpm_dram_ctrl #(
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_RAS(T_RAS),
        .T_RAS_MAX(T_RAS_MAX), .REF_INTERVAL(REF_INTERVAL)
    ) u_fpm_dram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(rdq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Memory model: reacts to the strobes as sampled at each rising edge
    logic [3:0] mem [int];
    logic       p_ras = 1'b1, p_cas = 1'b1;
    int hi_run = 1000, lo_run = 0, prev_cas_at = -1;
    int act_cnt = 0, cbr_cnt = 0, rise_cnt = 0;
    int v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r7 = 0, v_r8 = 0, v_r9 = 0;
    logic [9:0] m_row = '0, m_col = '0;
    bit cbr_wait = 1'b0;

    always @(posedge clk) begin
        int k;
        if (rst) begin
            p_ras = 1'b1; p_cas = 1'b1; hi_run = 1000; lo_run = 0; cbr_wait = 1'b0;
        end else begin
            cyc++;
            if (cbr_wait) begin
                if (!(p_ras && !dram_ras_n)) v_r8++;
                cbr_wait = 1'b0;
            end
            if (p_ras && !dram_ras_n) begin
                if (hi_run < T_RP) v_r5++;
                if (dram_cas_n) begin
                    act_cnt++;
                    m_row = dram_addr;
                end
                hi_run = 0;
                prev_cas_at = -1;
            end
            if (!p_ras && dram_ras_n) begin
                if (lo_run < T_RAS) v_r6++;
                if (lo_run > LIMIT) v_r7++;
                rise_cnt++;
                lo_run = 0;
            end
            if (p_cas && !dram_cas_n) begin
                if (!dram_ras_n) begin
                    if (lo_run < T_RCD) v_r9++;
                    if (prev_cas_at >= 0 && (lo_run - prev_cas_at) < T_CAS + T_CP) v_r4++;
                    prev_cas_at = lo_run;
                    m_col = dram_addr;
                    k = int'({m_row, m_col});
                    if (!dram_we_n) begin
                        if (!dram_dq_oe) v_r3++;
                        mem[k] = dram_dq_out;
                    end else if (!dram_oe_n) begin
                        rdq <= mem.exists(k) ? mem[k] : 4'h0;
                    end
                end else begin
                    cbr_cnt++;
                    cbr_wait = 1'b1;
                end
            end
            if (dram_ras_n) hi_run++;
            else            lo_run++;
            p_ras = dram_ras_n;
            p_cas = dram_cas_n;
        end
    end

    // Scoreboard
    logic [3:0] ref_mem [int];
    logic [3:0] exp_q [$];

    task automatic do_req(input logic [19:0] a, input logic w, input logic [3:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_we = w; req_wdata = d;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        if (w) ref_mem[int'(a)] = d;
        else   exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 4'h0);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic check_map(input logic [19:0] a);
        repeat (3) @(negedge clk);
        chk(m_row == a[19:10], "R2 row", int'(m_row), int'(a[19:10]));
        chk(m_col == a[9:0], "R2 col", int'(m_col), int'(a[9:0]));
    endtask

    task automatic wait_refresh();
        int c = cbr_cnt;
        while (cbr_cnt == c) @(negedge clk);
        repeat (T_RAS + T_RP + 4) @(negedge clk);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected read", int'(rd_data), -1);
            end else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R3 read data", int'(rd_data), int'(e));
            end
        end
    end

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        int a0, c0, r0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes in reset", 0, 1);
        chk(!dram_dq_oe && !rd_valid, "R1 outputs in reset", int'(dram_dq_oe), 0);
        chk(!req_ready, "R10 ready in reset", int'(req_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && !req_ready, "R1 first cycle", int'(dram_ras_n), 1);

        // R2/R3: single write then read back
        do_req(20'h12345, 1'b1, 4'h5);
        check_map(20'h12345);
        do_req(20'h12345, 1'b0, 4'h0);
        repeat (8) @(negedge clk);

        // R4: page hits after a refresh so no closure intervenes
        wait_refresh();
        a0 = act_cnt;
        for (int i = 1; i <= 4; i++) do_req({10'h2AB, 10'(i)}, 1'b1, 4'(i + 8));
        for (int i = 1; i <= 4; i++) do_req({10'h2AB, 10'(i)}, 1'b0, 4'h0);
        repeat (10) @(negedge clk);
        chk(act_cnt - a0 == 1, "R4 activations on page hits", act_cnt - a0, 1);

        // R5: row miss closes and reopens
        a0 = act_cnt;
        do_req({10'h155, 10'h003}, 1'b1, 4'h9);
        check_map({10'h155, 10'h003});
        do_req({10'h2AB, 10'h002}, 1'b0, 4'h0);
        repeat (10) @(negedge clk);
        chk(act_cnt - a0 == 2, "R5 activations on misses", act_cnt - a0, 2);

        // R7: idle page is closed by the age limit, not by refresh
        wait_refresh();
        do_req({10'h0F0, 10'h011}, 1'b0, 4'h0);
        r0 = rise_cnt;
        c0 = cbr_cnt;
        repeat (T_RAS_MAX + 30) @(negedge clk);
        chk(dram_ras_n == 1'b1, "R7 idle page closed", int'(dram_ras_n), 1);
        chk(rise_cnt - r0 == 1 && cbr_cnt == c0, "R7 closed by age", rise_cnt - r0, 1);

        // R8: refresh deadlines collide with a stream of page hits
        c0 = cbr_cnt;
        a0 = act_cnt;
        for (int i = 0; i < 300; i++) begin
            do_req({10'h3C3, 10'(i)}, 1'b1, 4'(i * 7 + 3));
            if (i > 0) do_req({10'h3C3, 10'(i - 1)}, 1'b0, 4'h0);
        end
        repeat (20) @(negedge clk);
        chk(cbr_cnt - c0 >= 2, "R8 refreshes during stream", cbr_cnt - c0, 2);
        chk(act_cnt - a0 >= 2, "R8 row reopened after refresh", act_cnt - a0, 2);
        chk(cbr_cnt >= cyc / REF_INTERVAL - 1, "R8 refresh rate", cbr_cnt, cyc / REF_INTERVAL - 1);

        // Timing observations collected by the model
        chk(v_r3 == 0, "R3 write drive", v_r3, 0);
        chk(v_r4 == 0, "R4 column spacing", v_r4, 0);
        chk(v_r5 == 0, "R5 precharge", v_r5, 0);
        chk(v_r6 == 0, "R6 ras low min", v_r6, 0);
        chk(v_r7 == 0, "R7 ras low max", v_r7, 0);
        chk(v_r8 == 0, "R8 refresh order", v_r8, 0);
        chk(v_r9 == 0, "R9 row to column delay", v_r9, 0);
        chk(exp_q.size() == 0, "R3 reads outstanding", exp_q.size(), 0);
        finish_up();
    end
endmodule